// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits between a serial slave engine and a byte-wide memory and handles the write path. The slave engine hands it a word address when a write command opens. It then passes on each data byte it receives. The controller collects those bytes in a one-page staging buffer, with the address moving only inside the current page. Nothing reaches the memory until the bus stop condition closes the command.

On a qualifying stop, the controller starts an internally timed write cycle and raises `busy_o`. The slave engine uses this flag to refuse every command, and the host learns that the cycle has ended when an addressing attempt is acknowledged again. The staged bytes are copied into the memory during the first page-length slots of that window. Only bytes actually delivered are copied, so the rest of the page keeps its old contents.

A write-protect input is sampled at the stop condition. When it is high, the staged bytes are dropped and no timed cycle starts. The shared address pointer is visible at `ptr_o`, and a registered read port serves the read side of the slave engine.

Top module: `pw_commit_ctrl`

## Requirements
- R1: After reset `busy_o` is 0 and `ptr_o` is 0.
- R2: While not busy, `addr_load_i` loads `addr_i` into the pointer and opens a write command. A later load in the same command replaces the address and discards any staged bytes.
- R3: Each data byte accepted in an open command is staged at the pointer's in-page offset (the lowest PAGE_W=6 bits). Only those offset bits then advance by one, and the page bits stay fixed.
- R4: Past the last byte of a page, the offset wraps to byte 0 of the same page. When more than 64 bytes are sent, the last byte sent to an offset is the one committed.
- R5: A commit writes only the offsets that received data. Other bytes of the page and of other pages keep their values.
- R6: The memory changes only after a stop closes an open command holding at least one staged byte. A stop with no staged byte starts no cycle and leaves the pointer at the loaded address.
- R7: `busy_o` rises on the clock edge that samples the qualifying stop and stays high for exactly max(TIMER_CYCLES, 64) clock cycles.
- R8: Before the stop, a read of a staged address returns the old memory contents.
- R9: While `busy_o` is high, address loads, data bytes and stops are ignored: the pointer and the memory are unchanged by them, and no second cycle follows.
- R10: If `wp_i` is high when the stop is sampled, the memory is unchanged and `busy_o` stays low. The value of `wp_i` earlier in the command does not matter.
- R11: After data bytes, and after a commit, `ptr_o` equals the last staged location plus one, wrapped within the page.
- R12: `rd_data_o` returns the memory byte at `rd_addr_i`, one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect, sampled at stop |
| addr_load_i | input | 1 | Word address received; opens a write command |
| addr_i | input | ADDR_W | Starting word address |
| data_valid_i | input | 1 | One data byte received |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Bus stop condition seen |
| busy_o | output | 1 | Timed write cycle in progress |
| ptr_o | output | ADDR_W | Shared word address pointer |
| rd_addr_i | input | ADDR_W | Read address from the read path |
| rd_data_o | output | 8 | Registered read data |

## Verification
The hardest situation to reach is traffic arriving while the timed cycle runs: an address load, data bytes and a stop that must all leave no trace. The bench issues that burst directly after a committing stop, while `busy_o` is high. It then checks the pointer and the entire memory, and confirms that no second cycle starts. Wrap-around overwriting is reached with commands longer than one and two pages from mid-page offsets. A separate case lowers write protect just before the stop, to show that only its value at the stop counts.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int PW_PAGE_W  = 6;
    localparam int PW_BYTE_W  = 8;
    localparam int PW_PTR_MAX = 16;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_OPEN = 2'd1
    } pw_state_e;

    typedef struct packed {
        logic load;
        logic data;
        logic stop;
    } pw_evt_t;

    typedef struct packed {
        logic                 we;
        logic [PW_BYTE_W-1:0] wdata;
    } pw_wr_t;

    // advance only the low page_w bits of a pointer
    function automatic logic [PW_PTR_MAX-1:0] in_page_next(
        input logic [PW_PTR_MAX-1:0] p,
        input int                    page_w
    );
        logic [PW_PTR_MAX-1:0] mask;
        mask = PW_PTR_MAX'((32'd1 << page_w) - 32'd1);
        return (p & ~mask) | ((p + PW_PTR_MAX'(1)) & mask);
    endfunction

endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
    parameter int PAGE_W = pw_pkg::PW_PAGE_W,
    parameter int BYTE_W = pw_pkg::PW_BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              has_data_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [BYTE_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark_q;

    always_ff @(posedge clk_i) begin
        if (wr_i) begin
            slot_q[wr_idx_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            mark_q <= '0;
        end else if (wr_i) begin
            mark_q[wr_idx_i] <= 1'b1;
        end
    end

    assign rd_data_o  = slot_q[rd_idx_i];
    assign rd_vld_o   = mark_q[rd_idx_i];
    assign has_data_o = |mark_q;

    // R3: a staged byte leaves the buffer non-empty
    a_r3_stage_marks: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && !clr_i) |=> has_data_o);

    // R2: a reload discards staged bytes
    a_r2_clear_empties: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> !has_data_o);

endmodule

// File: rtl/pw_commit_timer.sv
module pw_commit_timer #(
    parameter int TIMER_CYCLES = 1000000,
    parameter int PAGE_W       = pw_pkg::PW_PAGE_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic              slot_vld_o,
    output logic [PAGE_W-1:0] slot_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int WR_CYC     = (TIMER_CYCLES > PAGE_BYTES) ? TIMER_CYCLES : PAGE_BYTES;
    localparam int CNT_W      = $clog2(WR_CYC + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] SLOTS = CNT_W'(PAGE_BYTES);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            cnt_q <= '0;
            if (start_i) begin
                busy_q <= 1'b1;
            end
        end else if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign busy_o     = busy_q;
    assign slot_vld_o = busy_q && (cnt_q < SLOTS);
    assign slot_o     = cnt_q[PAGE_W-1:0];

    // R7: busy rises right after an accepted start
    a_r7_busy_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> (busy_o && cnt_q == '0));

    // R7: busy holds until the final count
    a_r7_busy_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && cnt_q != LAST) |=> busy_o);

    // R7: busy drops after the final count
    a_r7_busy_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && cnt_q == LAST) |=> !busy_o);

endmodule

// File: rtl/pw_byte_ram.sv
module pw_byte_ram #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = pw_pkg::PW_BYTE_W
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
        rdata_o <= cell_q[raddr_i];
    end

endmodule

// File: rtl/pw_commit_ctrl.sv
module pw_commit_ctrl #(
    parameter int ADDR_W       = 10,
    parameter int PAGE_W       = pw_pkg::PW_PAGE_W,
    parameter int TIMER_CYCLES = 1000000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wp_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_valid_i,
    input  logic [7:0]        data_i,
    input  logic              stop_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] ptr_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    import pw_pkg::*;

    localparam int ROW_W = ADDR_W - PAGE_W;

    pw_state_e         state_q;
    logic [ADDR_W-1:0] ptr_q;
    pw_evt_t           evt;
    logic              busy;
    logic              commit_go;
    logic              has_data;
    logic              slot_vld;
    logic [PAGE_W-1:0] slot;
    logic [7:0]        slot_data;
    logic              slot_mark;
    pw_wr_t            wr;

    // event qualification: nothing is taken while the timed cycle runs
    always_comb begin
        evt.load  = addr_load_i && !busy;
        evt.data  = data_valid_i && !busy && (state_q == PW_OPEN) && !addr_load_i;
        evt.stop  = stop_i && !busy && !addr_load_i;
        commit_go = evt.stop && (state_q == PW_OPEN) && has_data && !wp_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PW_IDLE;
        end else if (evt.load) begin
            state_q <= PW_OPEN;
        end else if (evt.stop) begin
            state_q <= PW_IDLE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_q <= '0;
        end else if (evt.load) begin
            ptr_q <= addr_i;
        end else if (evt.data) begin
            ptr_q <= ADDR_W'(in_page_next(PW_PTR_MAX'(ptr_q), PAGE_W));
        end
    end

    pw_page_buf #(
        .PAGE_W (PAGE_W),
        .BYTE_W (8)
    ) u_buf (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (evt.load),
        .wr_i       (evt.data),
        .wr_idx_i   (ptr_q[PAGE_W-1:0]),
        .wr_data_i  (data_i),
        .rd_idx_i   (slot),
        .rd_data_o  (slot_data),
        .rd_vld_o   (slot_mark),
        .has_data_o (has_data)
    );

    pw_commit_timer #(
        .TIMER_CYCLES (TIMER_CYCLES),
        .PAGE_W       (PAGE_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (commit_go),
        .busy_o     (busy),
        .slot_vld_o (slot_vld),
        .slot_o     (slot)
    );

    always_comb begin
        wr.we    = slot_vld && slot_mark;
        wr.wdata = slot_data;
    end

    pw_byte_ram #(
        .ADDR_W (ADDR_W),
        .BYTE_W (8)
    ) u_ram (
        .clk_i   (clk_i),
        .we_i    (wr.we),
        .waddr_i ({ptr_q[ADDR_W-1:PAGE_W], slot}),
        .wdata_i (wr.wdata),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    assign busy_o = busy;
    assign ptr_o  = ptr_q;

    // R9: pointer frozen during the timed cycle
    a_r9_ptr_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |=> $stable(ptr_o));

    // R10: protected stop starts no cycle
    a_r10_wp_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_i && wp_i && !busy_o) |=> !busy_o);

    // R6: empty command starts no cycle
    a_r6_no_empty_commit: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_i && !busy_o && !has_data) |=> !busy_o);

    // R3: data bytes never move the page bits
    a_r3_row_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
        evt.data |=> (ptr_o[ADDR_W-1:PAGE_W] == $past(ptr_o[ADDR_W-1:PAGE_W])));

    // R6: memory is written only inside the timed cycle
    a_r6_write_in_window: assert property (@(posedge clk_i) disable iff (rst_i)
        wr.we |-> busy_o);

    // R1 width guard
    initial begin
        a_r1_geometry: assert (ROW_W > 0 && ADDR_W <= PW_PTR_MAX);
    end

endmodule

// File: tb/test_pw_commit_ctrl.sv
module test_pw_commit_ctrl;
    localparam int AW  = 8;
    localparam int TMR = 100;
    localparam int MEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          data_valid = 1'b0;
    logic [7:0]    data = '0;
    logic          stop = 1'b0;
    logic          busy;
    logic [AW-1:0] ptr;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;
    int mem_m [MEM];
    int pend  [64];
    bit touch [64];

    always #2.5 clk = ~clk;

    pw_commit_ctrl #(.ADDR_W(AW), .PAGE_W(6), .TIMER_CYCLES(TMR)) i_pw_commit_ctrl (
        .clk_i(clk), .rst_i(rst), .wp_i(wp), .addr_load_i(addr_load), .addr_i(addr),
        .data_valid_i(data_valid), .data_i(data), .stop_i(stop), .busy_o(busy),
        .ptr_o(ptr), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int a);
        addr_load = 1'b1; addr = AW'(a);
        @(negedge clk);
        addr_load = 1'b0;
        for (int i = 0; i < 64; i++) touch[i] = 1'b0;
    endtask

    task automatic do_byte(input int d);
        data_valid = 1'b1; data = 8'(d);
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic do_read(input int a, output int v);
        rd_addr = AW'(a);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic verify_mem(input string req);
        int v;
        for (int i = 0; i < MEM; i++) begin
            do_read(i, v);
            chk(req, v, mem_m[i]);
        end
    endtask

    task automatic wait_busy(input string req);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(req, n, TMR);
    endtask

    task automatic apply_pend(input int page);
        for (int i = 0; i < 64; i++)
            if (touch[i]) mem_m[page + i] = pend[i];
    endtask

    task automatic run_write(input int s, input int n, input int seed, input bit full);
        int page = s & ~63;
        int off  = s & 63;
        int v;
        do_load(s);
        for (int k = 0; k < n; k++) begin
            int d = (s * 7 + k * 13 + seed * 31) & 255;
            pend[(off + k) % 64]  = d;
            touch[(off + k) % 64] = 1'b1;
            do_byte(d);
        end
        if (full) begin
            chk("R11 ptr after data", int'(ptr), page + ((off + n) % 64));
            do_read(s, v);
            chk("R8 old data before stop", v, mem_m[s]);
        end
        do_stop();
        chk("R7 busy after stop", int'(busy), 1);
        wait_busy("R7 busy length");
        apply_pend(page);
        if (full) begin
            chk("R11 ptr after commit", int'(ptr), page + ((off + n) % 64));
            verify_mem("R4 R5 memory image");
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 ptr reset", int'(ptr), 0);

        // R3 fill every page with a full page
        for (int p = 0; p < MEM / 64; p++) run_write(p * 64, 64, p, 1'b0);
        verify_mem("R3 full page fill");

        // R4 R5 R11 partial pages and wraps
        run_write(5, 1, 10, 1'b1);
        run_write(60, 10, 11, 1'b1);
        run_write(128, 64, 12, 1'b1);
        run_write(70, 130, 13, 1'b1);
        run_write(255, 2, 14, 1'b1);
        run_write(192, 63, 15, 1'b1);

        // R2 reload replaces address and drops staged bytes
        do_load(20);
        do_byte(8'h11);
        do_load(100);
        pend[36] = 8'h5C; touch[36] = 1'b1;
        do_byte(8'h5C);
        chk("R2 reload ptr", int'(ptr), 101);
        do_stop();
        wait_busy("R2 busy length");
        apply_pend(64);
        verify_mem("R2 reload image");

        // R6 stop with no data
        do_load(77);
        do_stop();
        chk("R6 no busy", int'(busy), 0);
        repeat (5) @(negedge clk);
        chk("R6 still idle", int'(busy), 0);
        chk("R6 ptr kept", int'(ptr), 77);
        verify_mem("R6 memory unchanged");

        // R10 protected stop
        wp = 1'b1;
        do_load(130);
        do_byte(1); do_byte(2); do_byte(3);
        do_stop();
        chk("R10 no busy", int'(busy), 0);
        chk("R10 ptr advanced", int'(ptr), 133);
        wp = 1'b0;
        verify_mem("R10 memory unchanged");

        // R10 protect lowered before stop: commit proceeds
        wp = 1'b1;
        do_load(140);
        pend[12] = 8'hC3; touch[12] = 1'b1;
        do_byte(8'hC3);
        wp = 1'b0;
        do_stop();
        chk("R10 busy when clear at stop", int'(busy), 1);
        wait_busy("R10 busy length");
        apply_pend(128);
        do_read(140, v);
        chk("R10 committed byte", v, 8'hC3);

        // R9 traffic during busy
        do_load(10);
        pend[10] = 8'h21; touch[10] = 1'b1; do_byte(8'h21);
        pend[11] = 8'h22; touch[11] = 1'b1; do_byte(8'h22);
        pend[12] = 8'h23; touch[12] = 1'b1; do_byte(8'h23);
        do_stop();
        chk("R9 busy", int'(busy), 1);
        addr_load = 1'b1; addr = AW'(200);
        @(negedge clk);
        addr_load = 1'b0;
        do_byte(8'hAA); do_byte(8'hAB);
        do_stop();
        while (busy) @(negedge clk);
        apply_pend(0);
        chk("R9 ptr unchanged", int'(ptr), 13);
        repeat (TMR + 20) @(negedge clk);
        chk("R9 no second cycle", int'(busy), 0);
        verify_mem("R9 memory image");

        // R12 read latency: address change visible one clock later
        rd_addr = AW'(11);
        @(negedge clk);
        rd_addr = AW'(200);
        chk("R12 registered read", int'(rd_data), 8'h22);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule